// File: doc/BRIEF.md
# Zero-Page Indirect Z-Indexed Address Generator

This block forms the effective address for the zero-page indirect, Z-indexed addressing mode of an 8-bit processor core. When the decoder flags an instruction that uses this mode, the block reads a pointer out of page zero, starting at the operand byte. It reads one byte per cycle through a simple synchronous read port. It then adds the Z register to the pointer and presents the result with a one-cycle completion strobe.

The pointer is normally two bytes wide. The block widens it to four bytes when three conditions hold together:
- the core reports that the instruction directly before this one was the no-op prefix opcode;
- the opcode belongs to the group allowed to use the wide form;
- the instruction uses this addressing mode.

The prefix is one-shot: the core raises its indication only for the single instruction that follows the prefix, so no mode register exists. A wide result is a 28-bit physical address. A narrow result is a 16-bit logical address that is zero-extended and flagged as still needing bank translation, which happens outside this block.

Top module: `ind_ptr_agen`

## Requirements
- R1: Narrow form: a start with `prevPrefix`=0 reads the bytes at zero-page addresses zp and zp+1 (modulo 256, so $FF is followed by $00). It forms the little-endian 16-bit pointer, adds Z zero-extended, and keeps the sum modulo 2^16. `effAddr` bits 27:16 are zero and `needsXlate`=1.
- R2: Wide form: a start with `prevPrefix`=1 and `wideOk`=1 reads the bytes at zp, zp+1, zp+2 and zp+3 (modulo 256). It forms a little-endian 32-bit pointer and adds Z zero-extended, with carries propagating into the upper bytes. `effAddr` is bits 27:0 of the sum and `needsXlate`=0.
- R3: Wide pointer bytes $11,$22,$33,$04 with Z=$05 give `effAddr`=$4332216.
- R4: In the wide form, pointer bits 31:28 have no effect on `effAddr`.
- R5: A start with `prevPrefix`=1 but `wideOk`=0 behaves exactly as the narrow form of R1.
- R6: Timing: if start is sampled at edge 0, `memRd` is high with `memAddr`=zp+i for the i-th cycle after that edge, with i starting at 0. This lasts 2 cycles in the narrow form and 4 in the wide form. `done` is a single-cycle pulse in the 4th cycle after edge 0 in the narrow form and the 6th in the wide form, so the wide form costs two more cycles.
- R7: A start raised while `busy`=1 is ignored. The operation in progress completes with its own operands and no extra read occurs.
- R8: After reset, `busy`, `memRd` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Decoder flag: this instruction uses zero-page indirect Z-indexed mode |
| wideOk | input | 1 | Opcode is in the group permitted to use the wide pointer |
| prevPrefix | input | 1 | Instruction immediately before was the no-op prefix |
| zpAddr | input | 8 | Zero-page operand byte |
| zReg | input | 8 | Z index register |
| memRd | output | 1 | Read request to the zero-page port |
| memAddr | output | 8 | Zero-page byte address being read |
| memData | input | 8 | Read data, valid the cycle after the request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle strobe: effAddr is valid |
| effAddr | output | 28 | Effective address |
| needsXlate | output | 1 | 1 when effAddr is a 16-bit logical address still to be bank-translated |

## Verification
The bench builds the block with its default parameters: a 28-bit physical address, a 2-byte narrow pointer and a 4-byte wide pointer. At this size every zero-page operand value can be swept in both pointer forms. That sweep reaches each way the fetch addresses can wrap past $FF, including the wide case where the wrap falls on any of the four bytes. A full sweep of Z over a pointer that ends in $FF exercises the carry out of bit 15 in both forms, so the bench sees it dropped in the narrow form and propagated in the wide form.

// File: rtl/agen_pkg.sv
package agen_pkg;
  localparam int NARROW_BYTES = 2;
  localparam int WIDE_BYTES   = 4;
  localparam int IDX_W        = $clog2(WIDE_BYTES);
  localparam int PTR_W        = 8 * WIDE_BYTES;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } agenState_t;

  typedef struct packed {
    logic             load;
    logic             fetch;
    logic [IDX_W-1:0] fetchIdx;
    logic             capEn;
    logic [IDX_W-1:0] capIdx;
  } agenCtl_t;
endpackage

// File: rtl/agen_ctrl.sv
module agen_ctrl
  import agen_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     wideMode,
  output agenCtl_t ctl,
  output logic     busy,
  output logic     done
);
  localparam logic [IDX_W-1:0] LAST_NARROW = IDX_W'(NARROW_BYTES - 1);
  localparam logic [IDX_W-1:0] LAST_WIDE   = IDX_W'(WIDE_BYTES - 1);

  agenState_t       state;
  logic [IDX_W-1:0] cnt;
  logic             rdPend;
  logic [IDX_W-1:0] pendIdx;
  logic [IDX_W-1:0] lastIdx;

  assign lastIdx = wideMode ? LAST_WIDE : LAST_NARROW;

  always_comb begin
    ctl          = '0;
    ctl.load     = (state == ST_IDLE) && start;
    ctl.fetch    = (state == ST_FETCH);
    ctl.fetchIdx = cnt;
    ctl.capEn    = rdPend;
    ctl.capIdx   = pendIdx;
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      rdPend  <= 1'b0;
      pendIdx <= '0;
    end else begin
      rdPend  <= ctl.fetch;
      pendIdx <= cnt;
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (start) state <= ST_FETCH;
        end
        ST_FETCH: begin
          if (cnt == lastIdx) state <= ST_DRAIN;
          else                cnt   <= cnt + 1'b1;
        end
        ST_DRAIN: state <= ST_DONE;
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/agen_dp.sv
module agen_dp
  import agen_pkg::*;
#(
  parameter int ADDR_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  agenCtl_t          ctl,
  input  logic              wideSel,
  input  logic [7:0]        zpAddr,
  input  logic [7:0]        zReg,
  input  logic [7:0]        memData,
  output logic [7:0]        memAddr,
  output logic              wideMode,
  output logic [ADDR_W-1:0] effAddr
);
  localparam int NARROW_W = 8 * NARROW_BYTES;

  logic [7:0]       zpHeld;
  logic [7:0]       zHeld;
  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] wideSum;
  logic [NARROW_W-1:0] narrowSum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zpHeld   <= '0;
      zHeld    <= '0;
      wideMode <= 1'b0;
    end else if (ctl.load) begin
      zpHeld   <= zpAddr;
      zHeld    <= zReg;
      wideMode <= wideSel;
    end
  end

  for (genvar b = 0; b < WIDE_BYTES; b++) begin : g_ptrByte
    always_ff @(posedge clk) begin
      if (!rst_n || ctl.load)
        ptr[8*b +: 8] <= '0;
      else if (ctl.capEn && ctl.capIdx == IDX_W'(b))
        ptr[8*b +: 8] <= memData;
    end
  end

  assign memAddr   = zpHeld + 8'(ctl.fetchIdx);
  assign wideSum   = ptr + PTR_W'(zHeld);
  assign narrowSum = ptr[NARROW_W-1:0] + NARROW_W'(zHeld);
  assign effAddr   = wideMode ? wideSum[ADDR_W-1:0] : ADDR_W'(narrowSum);
endmodule

// File: rtl/ind_ptr_agen.sv
module ind_ptr_agen
  import agen_pkg::*;
#(
  parameter int ADDR_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wideOk,
  input  logic              prevPrefix,
  input  logic [7:0]        zpAddr,
  input  logic [7:0]        zReg,
  output logic              memRd,
  output logic [7:0]        memAddr,
  input  logic [7:0]        memData,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] effAddr,
  output logic              needsXlate
);
  agenCtl_t ctl;
  logic     wideMode;

  agen_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .wideMode(wideMode),
    .ctl(ctl), .busy(busy), .done(done)
  );

  agen_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .wideSel(prevPrefix && wideOk),
    .zpAddr(zpAddr), .zReg(zReg), .memData(memData), .memAddr(memAddr),
    .wideMode(wideMode), .effAddr(effAddr)
  );

  assign memRd      = ctl.fetch;
  assign needsXlate = ~wideMode;
endmodule

// File: rtl/agen_chk.sv
module agen_chk #(
  parameter int ADDR_W = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [7:0]        zpAddr,
  input logic              memRd,
  input logic [7:0]        memAddr,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] effAddr,
  input logic              needsXlate
);
  // R6: completion strobe lasts one cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: consecutive reads walk up page zero by one
  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (memRd && $past(memRd)) |-> memAddr == $past(memAddr) + 8'd1);

  // R6: accepted start leads to a read of the operand address
  p_first_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (memRd && memAddr == $past(zpAddr)));

  // R1: a narrow result never reaches above 16 bits
  p_narrow_upper_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && needsXlate) |-> effAddr[ADDR_W-1:16] == '0);

  // R7, R8: no reads while idle
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !memRd && !done);
endmodule

bind ind_ptr_agen agen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .zpAddr(zpAddr),
  .memRd(memRd), .memAddr(memAddr), .busy(busy), .done(done),
  .effAddr(effAddr), .needsXlate(needsXlate)
);

// File: tb/sim_ind_ptr_agen.sv
module sim_ind_ptr_agen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, wideOk = 1'b0, prevPrefix = 1'b0;
  logic [7:0]  zpAddr = '0, zReg = '0;
  logic        memRd, busy, done, needsXlate;
  logic [7:0]  memAddr;
  logic [7:0]  memData = '0;
  logic [27:0] effAddr;
  logic [7:0]  mem [256];

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ind_ptr_agen u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .wideOk(wideOk),
    .prevPrefix(prevPrefix), .zpAddr(zpAddr), .zReg(zReg),
    .memRd(memRd), .memAddr(memAddr), .memData(memData),
    .busy(busy), .done(done), .effAddr(effAddr), .needsXlate(needsXlate)
  );

  always_ff @(posedge clk) if (memRd) memData <= mem[memAddr];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expAddr(logic [7:0] zp, logic [7:0] z, bit wide);
    logic [31:0] p;
    p = {mem[8'(zp+3)], mem[8'(zp+2)], mem[8'(zp+1)], mem[zp]};
    if (wide) return (p + 32'(z)) & 32'h0FFF_FFFF;
    return 32'((p[15:0] + 16'(z)) & 16'hFFFF);
  endfunction

  // Runs one operation; optional second start while busy (R7).
  task automatic runOp(string req, logic [7:0] zp, logic [7:0] z, bit pre, bit ok,
                       bit poke, bit verbose);
    bit wide;
    int nBytes, doneAt;
    logic [31:0] exp;
    logic [31:0] res;
    logic        xl;
    wide   = pre && ok;
    nBytes = wide ? 4 : 2;
    exp    = expAddr(zp, z, wide);
    doneAt = -1;
    res    = '0;
    xl     = 1'b0;
    @(negedge clk);
    start = 1'b1; zpAddr = zp; zReg = z; prevPrefix = pre; wideOk = ok;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (poke && k == 2) begin
        start = 1'b1; zpAddr = zp ^ 8'h55; zReg = z ^ 8'hA5; prevPrefix = 1'b0;
      end
      if (verbose && k <= nBytes) begin
        check({req, " R6 read strobe"}, 32'(memRd), 32'd1);
        check({req, " R6 read addr"}, 32'(memAddr), 32'(8'(zp + 8'(k-1))));
      end
      if (verbose && k > nBytes) check({req, " R7 no extra read"}, 32'(memRd), 32'd0);
      if (done) begin
        if (doneAt < 0) begin doneAt = k; res = 32'(effAddr); xl = needsXlate; end
        else check({req, " R6 done width"}, 32'(k), 32'(doneAt));
      end
    end
    start = 1'b0;
    check({req, " R6 done cycle"}, 32'(doneAt), 32'(nBytes + 2));
    check({req, " effAddr"}, res, exp);
    check({req, " needsXlate"}, 32'(xl), 32'(!wide));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 13) ^ (i >> 3));
    repeat (3) @(negedge clk);
    check("R8 busy", 32'(busy), 32'd0);
    check("R8 memRd", 32'(memRd), 32'd0);
    check("R8 done", 32'(done), 32'd0);
    rst_n = 1'b1;

    // R3: worked example
    mem[8'h40] = 8'h11; mem[8'h41] = 8'h22; mem[8'h42] = 8'h33; mem[8'h43] = 8'h04;
    runOp("R3", 8'h40, 8'h05, 1'b1, 1'b1, 1'b0, 1'b1);
    check("R3 literal", 32'(effAddr), 32'h0433_2216);
    // R4: upper nibble ignored
    mem[8'h43] = 8'hF4;
    runOp("R4", 8'h40, 8'h05, 1'b1, 1'b1, 1'b0, 1'b1);
    check("R4 literal", 32'(effAddr), 32'h0433_2216);

    // R1/R2/R5: every operand value in each selection
    for (int zp = 0; zp < 256; zp++) begin
      runOp("R1", 8'(zp), 8'(zp * 7), 1'b0, 1'b1, 1'b0, zp > 250);
      runOp("R2", 8'(zp), 8'(zp ^ 8'hC3), 1'b1, 1'b1, 1'b0, zp > 250);
      runOp("R5", 8'(zp), 8'(zp + 9), 1'b1, 1'b0, 1'b0, zp > 250);
    end

    // Carry out of bit 15: narrow drops it, wide keeps it (R1, R2)
    mem[8'h80] = 8'hF0; mem[8'h81] = 8'hFF; mem[8'h82] = 8'h12; mem[8'h83] = 8'h00;
    for (int z = 0; z < 256; z++) begin
      runOp("R1 carry", 8'h80, 8'(z), 1'b0, 1'b0, 1'b0, 1'b0);
      runOp("R2 carry", 8'h80, 8'(z), 1'b1, 1'b1, 1'b0, 1'b0);
    end

    // R7: start while busy ignored
    runOp("R7 narrow", 8'h10, 8'h3C, 1'b0, 1'b0, 1'b1, 1'b1);
    runOp("R7 wide", 8'hFE, 8'h3C, 1'b1, 1'b1, 1'b1, 1'b1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule